// File: doc/BRIEF.md
# Per-Opcode Trivial Taint Propagation Filter

This block sits in the in-order taint propagation stage of a core and decides, within the same cycle, whether the taint result of a retiring instruction can be found without a lookup. It takes the instruction's opcode and up to three input taint states: two source registers and one memory word. Each input has a valid bit. An input whose valid bit is low is treated as the safe all-zeros state. A per-opcode rule table gives a 2-bit rule code. From that code and the masked inputs, the block raises `resolved` and supplies the output taint state. When `resolved` stays low, a slower path outside this block has to compute the result.

Two trivial rules are supported. The zero-preserving rule resolves only when every input is the safe state, and the result is then the safe state. The unary rule also does this. In addition, when exactly one input is non-zero, it forwards that input's state unchanged.

The rule table holds 256 two-bit entries. A word-wide configuration port writes and reads it back, so system software can save and restore all of it on a context switch.

Top module: `tfilt_prop_filter`

## Requirements
- R1: After reset every table entry holds rule code 00. All 16 configuration words read as zero, and no opcode resolves.
- R2: A write of `cfg_wdata` to word `cfg_addr` while `cfg_we` is high takes effect at that rising clock edge. From the next cycle on, `cfg_rdata` returns the written value when that address is presented. Words that were not addressed keep their contents.
- R3: The rule for opcode `o` is stored in bits `[2*(o%16)+1 : 2*(o%16)]` of configuration word `o/16`.
- R4: Rule codes 00 and 11 never resolve an instruction, whatever the inputs are.
- R5: Rule code 01 resolves exactly when all three masked inputs are zero, and the output state is then zero.
- R6: Rule code 10 resolves exactly when at most one masked input is non-zero. The output is then that input's state, or zero when no input is non-zero.
- R7: An input whose valid bit is low counts as zero for every rule, whatever its state value.
- R8: `resolved` and `out_state` are combinational functions of the opcode, the inputs and the table contents. A change of the inputs shows within the same cycle, with no clock edge between.
- R9: Whenever `resolved` is low, `out_state` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Table word at `cfg_addr` |
| op_code | input | 8 | Opcode of the retiring instruction |
| src1_state | input | 2 | Taint state of first source register |
| src1_vld | input | 1 | First source is used |
| src2_state | input | 2 | Taint state of second source register |
| src2_vld | input | 1 | Second source is used |
| mem_state | input | 2 | Taint state of the memory word |
| mem_vld | input | 1 | Memory operand is used |
| resolved | output | 1 | Result computed trivially |
| out_state | output | 2 | Output taint state (zero when unresolved) |

## Verification
The table is loaded with a pattern that puts every rule code at many opcodes. All 256 opcodes are then probed with all-zero inputs, which tells apart the active rules from the inactive ones and catches any misplaced field. For one opcode of each rule code, every combination of the three 2-bit states and the three valid bits is applied. This separates zero inputs from single non-zero inputs and from multiple non-zero inputs. It also separates a masked non-zero input from a real one, and shows which input is forwarded. Table save and restore is checked by writing and reading back all words and by rewriting a single word.

// File: rtl/tfilt_pkg.sv
package tfilt_pkg;

  localparam int RULE_W = 2;

  typedef enum logic [RULE_W-1:0] {
    RULE_NEVER = 2'b00,
    RULE_ZERO  = 2'b01,
    RULE_UNARY = 2'b10,
    RULE_RSVD  = 2'b11
  } rule_e;

  // true for the codes that may resolve an instruction
  function automatic logic rule_can_resolve(rule_e r);
    return (r == RULE_ZERO) || (r == RULE_UNARY);
  endfunction

endpackage

// File: rtl/tfilt_rule_table.sv
module tfilt_rule_table
  import tfilt_pkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int CFG_DW = 32,
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic [OPC_W-1:0]  op_code,
  output rule_e             rule
);

  localparam int OPS_PER_WORD = CFG_DW / RULE_W;
  localparam int SEL_W        = $clog2(OPS_PER_WORD);
  localparam int NWORDS       = 1 << CFG_AW;

  logic [CFG_DW-1:0] words [NWORDS];

  // one register word per configuration address
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit;
    assign hit = cfg_we && (cfg_addr == CFG_AW'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words[w] <= '0;
      else if (hit) words[w] <= cfg_wdata;
    end
  end

  assign cfg_rdata = words[cfg_addr];

  // lookup: upper opcode bits select the word, lower bits the field
  logic [CFG_AW-1:0] word_sel;
  logic [SEL_W-1:0]  field_sel;
  logic [CFG_DW-1:0] sel_word;
  logic [RULE_W-1:0] rule_bits;

  assign word_sel  = op_code[OPC_W-1 -: CFG_AW];
  assign field_sel = op_code[SEL_W-1:0];
  assign sel_word  = words[word_sel];
  assign rule_bits = sel_word[field_sel*RULE_W +: RULE_W];
  assign rule      = rule_e'(rule_bits);

  // R2
  cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && (cfg_addr == $past(cfg_addr))) |-> (cfg_rdata == $past(cfg_wdata)));

endmodule

// File: rtl/tfilt_operand_mask.sv
module tfilt_operand_mask #(
  parameter int STATE_W = 2,
  parameter int N_OPND  = 3
) (
  input  logic [N_OPND-1:0][STATE_W-1:0] st_in,
  input  logic [N_OPND-1:0]              vld,
  output logic [N_OPND-1:0][STATE_W-1:0] st_masked,
  output logic [N_OPND-1:0]              opnd_nz
);

  for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
    assign st_masked[i] = vld[i] ? st_in[i] : '0;
    assign opnd_nz[i]   = |st_masked[i];
  end

endmodule

// File: rtl/tfilt_rule_eval.sv
module tfilt_rule_eval
  import tfilt_pkg::*;
#(
  parameter int STATE_W = 2,
  parameter int N_OPND  = 3
) (
  input  rule_e                          rule,
  input  logic [N_OPND-1:0][STATE_W-1:0] st_masked,
  input  logic [N_OPND-1:0]              opnd_nz,
  output logic                           resolved,
  output logic [STATE_W-1:0]             out_state,
  output logic [$clog2(N_OPND+1)-1:0]    nz_count
);

  localparam int CNT_W = $clog2(N_OPND + 1);

  function automatic logic [CNT_W-1:0] count_nonzero(logic [N_OPND-1:0] nz);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < N_OPND; i++) c = c + CNT_W'(nz[i]);
    return c;
  endfunction

  // with at most one non-zero operand the OR equals that operand
  function automatic logic [STATE_W-1:0] merge_operands(
      logic [N_OPND-1:0][STATE_W-1:0] s);
    logic [STATE_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_OPND; i++) m = m | s[i];
    return m;
  endfunction

  logic [STATE_W-1:0] merged;

  assign nz_count = count_nonzero(opnd_nz);
  assign merged   = merge_operands(st_masked);

  always_comb begin
    resolved  = 1'b0;
    out_state = '0;
    unique case (rule)
      RULE_ZERO: begin
        resolved = (nz_count == '0);
      end
      RULE_UNARY: begin
        resolved  = (nz_count <= CNT_W'(1));
        out_state = resolved ? merged : '0;
      end
      default: begin
        resolved  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/tfilt_prop_filter.sv
module tfilt_prop_filter
  import tfilt_pkg::*;
#(
  parameter int OPC_W   = 8,
  parameter int STATE_W = 2,
  parameter int CFG_DW  = 32,
  parameter int CFG_AW  = $clog2(((1 << OPC_W) * 2) / CFG_DW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata,
  input  logic [OPC_W-1:0]   op_code,
  input  logic [STATE_W-1:0] src1_state,
  input  logic               src1_vld,
  input  logic [STATE_W-1:0] src2_state,
  input  logic               src2_vld,
  input  logic [STATE_W-1:0] mem_state,
  input  logic               mem_vld,
  output logic               resolved,
  output logic [STATE_W-1:0] out_state
);

  localparam int N_OPND = 3;
  localparam int CNT_W  = $clog2(N_OPND + 1);

  rule_e                          rule;
  logic [N_OPND-1:0][STATE_W-1:0] st_vec;
  logic [N_OPND-1:0][STATE_W-1:0] st_masked;
  logic [N_OPND-1:0]              vld_vec;
  logic [N_OPND-1:0]              opnd_nz;
  logic [CNT_W-1:0]               nz_count;

  assign st_vec  = {mem_state, src2_state, src1_state};
  assign vld_vec = {mem_vld, src2_vld, src1_vld};

  tfilt_rule_table #(
    .OPC_W (OPC_W),
    .CFG_DW(CFG_DW),
    .CFG_AW(CFG_AW)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .op_code  (op_code),
    .rule     (rule)
  );

  tfilt_operand_mask #(
    .STATE_W(STATE_W),
    .N_OPND (N_OPND)
  ) u_mask (
    .st_in    (st_vec),
    .vld      (vld_vec),
    .st_masked(st_masked),
    .opnd_nz  (opnd_nz)
  );

  tfilt_rule_eval #(
    .STATE_W(STATE_W),
    .N_OPND (N_OPND)
  ) u_eval (
    .rule     (rule),
    .st_masked(st_masked),
    .opnd_nz  (opnd_nz),
    .resolved (resolved),
    .out_state(out_state),
    .nz_count (nz_count)
  );

  // R4
  inactive_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rule_can_resolve(rule) |-> !resolved);

  // R5
  zero_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rule == RULE_ZERO && resolved) |-> (opnd_nz == '0 && out_state == '0));

  // R6
  unary_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rule == RULE_UNARY && $countones(opnd_nz) >= 2) |-> !resolved);

  // R6
  unary_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rule == RULE_UNARY && resolved) |->
      (out_state == '0 || out_state == st_masked[0] ||
       out_state == st_masked[1] || out_state == st_masked[2]));

  // R7
  masked_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(opnd_nz & ~vld_vec) && ((opnd_nz & ~vld_vec) == '0));

  // R9
  unresolved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resolved |-> (out_state == '0));

endmodule

// File: tb/tfilt_prop_filter_bench.sv
`timescale 1ns/1ps
module tfilt_prop_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [7:0]  op_code;
  logic [1:0]  src1_state, src2_state, mem_state;
  logic        src1_vld, src2_vld, mem_vld;
  logic        resolved;
  logic [1:0]  out_state;

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] exp_rule [256];

  always #5 clk = ~clk;

  tfilt_prop_filter u_tfilt_prop_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .op_code(op_code),
    .src1_state(src1_state), .src1_vld(src1_vld),
    .src2_state(src2_state), .src2_vld(src2_vld),
    .mem_state(mem_state), .mem_vld(mem_vld),
    .resolved(resolved), .out_state(out_state)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] model_word(int w);
    logic [31:0] d = '0;
    for (int k = 0; k < 16; k++) d[2*k +: 2] = exp_rule[w*16 + k];
    return d;
  endfunction

  // expected {resolved, out_state} derived from the rule definitions
  function automatic logic [2:0] model_out(logic [1:0] r, logic [1:0] a,
      logic [1:0] b, logic [1:0] m, logic [2:0] v);
    logic [1:0] ea, eb, em, only;
    int cnt;
    ea = v[0] ? a : 2'd0;
    eb = v[1] ? b : 2'd0;
    em = v[2] ? m : 2'd0;
    cnt = 0; only = 2'd0;
    if (ea != 0) begin cnt++; only = ea; end
    if (eb != 0) begin cnt++; only = eb; end
    if (em != 0) begin cnt++; only = em; end
    if (r == 2'b01) return (cnt == 0) ? 3'b100 : 3'b000;
    if (r == 2'b10) return (cnt <= 1) ? {1'b1, only} : 3'b000;
    return 3'b000;
  endfunction

  task automatic drive(logic [7:0] o, logic [1:0] a, logic [1:0] b,
      logic [1:0] m, logic [2:0] v);
    op_code = o; src1_state = a; src2_state = b; mem_state = m;
    {mem_vld, src2_vld, src1_vld} = v;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    drive(8'd0, 2'd0, 2'd0, 2'd0, 3'b000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: cleared table, nothing resolves
    for (int w = 0; w < 16; w++) begin
      cfg_addr = 4'(w); #1;
      chk("R1 word", cfg_rdata, 32'h0);
    end
    for (int o = 0; o < 256; o += 37) begin
      drive(8'(o), 2'd0, 2'd0, 2'd0, 3'b111); #1;
      chk("R1 resolved", {31'd0, resolved}, 32'd0);
    end

    // R2: load the whole table and read it back
    for (int o = 0; o < 256; o++) exp_rule[o] = 2'((o ^ (o >> 2) ^ (o >> 5)) & 3);
    for (int w = 0; w < 16; w++) cfg_write(4'(w), model_word(w));
    for (int w = 0; w < 16; w++) begin
      cfg_addr = 4'(w); #1;
      chk("R2 readback", cfg_rdata, model_word(w));
    end

    // R2: rewrite one word, neighbours untouched
    for (int k = 0; k < 16; k++) exp_rule[5*16 + k] = 2'(k & 3);
    cfg_write(4'd5, model_word(5));
    for (int w = 4; w < 7; w++) begin
      cfg_addr = 4'(w); #1;
      chk("R2 single", cfg_rdata, model_word(w));
    end

    // R3: field placement, probed with all-safe inputs on every opcode
    for (int o = 0; o < 256; o++) begin
      drive(8'(o), 2'd0, 2'd0, 2'd0, 3'b111); #1;
      chk("R3 map", {31'd0, resolved},
          {31'd0, (exp_rule[o] == 2'b01 || exp_rule[o] == 2'b10)});
    end

    // R4 R5 R6 R9: exhaustive inputs for one opcode of each rule code
    for (int r = 0; r < 4; r++) begin
      int op = 0;
      for (int o = 255; o >= 0; o--) if (exp_rule[o] == 2'(r)) op = o;
      for (int v = 0; v < 8; v++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int m = 0; m < 4; m++) begin
              logic [2:0] e;
              string tag;
              e = model_out(2'(r), 2'(a), 2'(b), 2'(m), 3'(v));
              drive(8'(op), 2'(a), 2'(b), 2'(m), 3'(v)); #1;
              tag = (r == 1) ? "R5" : (r == 2) ? "R6" : "R4";
              chk(tag, {31'd0, resolved}, {31'd0, e[2]});
              chk(e[2] ? tag : "R9", {30'd0, out_state}, {30'd0, e[1:0]});
            end
    end

    // R7: invalid non-zero inputs are ignored
    begin
      int op01 = 0, op10 = 0;
      for (int o = 255; o >= 0; o--) begin
        if (exp_rule[o] == 2'b01) op01 = o;
        if (exp_rule[o] == 2'b10) op10 = o;
      end
      drive(8'(op01), 2'd3, 2'd2, 2'd1, 3'b000); #1;
      chk("R7 zero rule", {31'd0, resolved}, 32'd1);
      drive(8'(op10), 2'd3, 2'd2, 2'd1, 3'b010); #1;
      chk("R7 unary res", {31'd0, resolved}, 32'd1);
      chk("R7 unary out", {30'd0, out_state}, 32'd2);

      // R8: change inputs between edges, result seen before the next edge
      @(posedge clk); #1;
      drive(8'(op10), 2'd0, 2'd0, 2'd3, 3'b100); #1;
      chk("R8 same cycle", {29'd0, resolved, out_state}, {29'd0, 3'b111});
      drive(8'(op10), 2'd1, 2'd0, 2'd3, 3'b101); #1;
      chk("R8 same cycle", {31'd0, resolved}, 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule